// File: doc/BRIEF.md
# S/PDIF User and Channel-Status Bit Capture

This block sits behind an S/PDIF receiver that has already recovered the subframes of the incoming stream. Each accepted subframe brings its channel identity, its user bit, its channel-status bit and a flag marking the first subframe of a 192-frame block. The block keeps only the subframes of the channel chosen by `chan_sel`. It places each bit at the position equal to its frame index within the block, and so builds a 192-bit user buffer and a 192-bit channel-status buffer.

When the bit of frame 191 arrives, both buffers are copied in one clock cycle into the readable registers. Software therefore always reads a complete block and never a partly filled one. Two sticky status flags report progress. One marks that a new block is available. The other marks that the receiver lost lock. Software clears each flag by writing a 1 to its bit in the status word.

The subframe input is a valid/ready stream. `sf_ready` is held high, so the block never applies back-pressure and a subframe is taken in every cycle where `sf_valid` is high. All fields are ignored in cycles where `sf_valid` is low. The register port is a plain port: writes take effect on the clock edge, and reads are combinational from `reg_addr`.

Top module: `spdif_ucb_capture`

## Requirements
- R1: After reset, every readable register (user words at addresses 0 to 5, channel-status words at addresses 6 to 11, status word at address 12) reads zero.
- R2: The user bit of frame n of a completed block appears at address n/32, bit n%32. Bit 0 of the word at address k is frame 32k, so byte 0 of a word holds the lowest frames. The channel-status bit of frame n appears at address 6+n/32, bit n%32.
- R3: The readable user and channel-status words change only in the cycle that captures frame 191. While a block is partly received, they keep showing the previous completed block.
- R4: Only subframes with `sf_chan` equal to `chan_sel` are captured. `sf_chan` is 0 for the first subframe of a frame and 1 for the second. The frame index advances once per captured subframe.
- R5: While `lock` is low, nothing is captured and the partial block is dropped. Readable words stay unchanged, and capture resumes only at the next subframe that has `sf_blk_start` set.
- R6: Status word bit 8 is set in the cycle a block is completed. Bit 9 is set in every cycle where `lock` is low. Bits 31 to 10 and bits 7 to 0 read zero.
- R7: A write to address 12 with data bit 8 or bit 9 at 1 clears that flag. A data bit at 0 leaves its flag unchanged.
- R8: If a flag is set and cleared in the same cycle, the set wins.
- R9: `sf_ready` is always 1. Cycles with `sf_valid` low have no effect, whatever the other subframe inputs carry.
- R10: A subframe with `sf_blk_start` set in the middle of a block restarts the count at frame 0. The earlier partial data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock | input | 1 | Receiver locked onto the incoming stream |
| chan_sel | input | 1 | Channel whose bits are captured (0 first, 1 second) |
| sf_valid | input | 1 | Subframe valid |
| sf_ready | output | 1 | Subframe ready, tied high |
| sf_chan | input | 1 | Channel of this subframe |
| sf_blk_start | input | 1 | Subframe begins a new 192-frame block |
| sf_ubit | input | 1 | User bit of the subframe |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The assertions check, on every cycle, the following behaviours:
- The readable words never move except on a completing capture.
- Loss of lock disarms the frame tracker.
- The frame index stays within the block.
- A completion or loss of lock leaves its flag set even against a simultaneous clear.
- The unused status bits stay zero.

Only the bench scenarios can show the rest:
- Each bit lands at the position its frame index dictates.
- The channel select picks the right subframes.
- A partial block cut short by lock loss or by a fresh block start leaves no trace.
- Idle cycles that carry garbage leave the result untouched.

// File: rtl/spdif_ucb_pkg.sv
package spdif_ucb_pkg;
  localparam int FRAMES_PER_BLOCK = 192;
  localparam int WORD_W           = 32;
  localparam int AVAIL_BIT        = 8;
  localparam int UNLOCK_BIT       = 9;
  localparam int BANKS            = 2;   // 0 = user bits, 1 = channel-status bits

  typedef enum logic [0:0] {
    BANK_USER = 1'b0,
    BANK_CHAN = 1'b1
  } bank_e;
endpackage

// File: rtl/ucb_frame_tracker.sv
module ucb_frame_tracker #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             chan_sel,
  input  logic             sf_valid,
  input  logic             sf_chan,
  input  logic             sf_blk_start,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  logic             armed;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] cur_idx;
  logic             take;

  // A block start always restarts the count, even mid-block.
  always_comb begin
    cur_idx = sf_blk_start ? '0 : idx;
    take    = sf_valid && lock && (sf_blk_start || armed) && (sf_chan == chan_sel);
    wr_en   = take;
    wr_idx  = cur_idx;
    commit  = take && (cur_idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      idx   <= '0;
    end else if (!lock) begin
      armed <= 1'b0;
      idx   <= '0;
    end else if (sf_valid) begin
      if (take) begin
        if (commit) begin
          armed <= 1'b0;
          idx   <= '0;
        end else begin
          armed <= 1'b1;
          idx   <= cur_idx + IDX_W'(1);
        end
      end else if (sf_blk_start) begin
        armed <= 1'b1;
        idx   <= '0;
      end
    end
  end

  a_r5_unlock_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !armed);
  a_r2_index_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < FRAMES);
  a_r5_wait_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!armed && idx == '0));
  a_r4_capture_selected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sf_chan == chan_sel && lock));
endmodule

// File: rtl/ucb_shadow_bank.sv
module ucb_shadow_bank #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              bit_in,
  input  logic              commit,
  output logic [FRAMES-1:0] vis
);
  logic [FRAMES-1:0] work;
  logic [FRAMES-1:0] work_nxt;

  // The copy includes the bit that arrives in the completing cycle.
  always_comb begin
    work_nxt = work;
    if (wr_en) work_nxt[wr_idx] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work <= '0;
      vis  <= '0;
    end else begin
      work <= work_nxt;
      if (commit) vis <= work_nxt;
    end
  end

  a_r3_atomic_update: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(vis));
  a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_idx) < FRAMES);
endmodule

// File: rtl/ucb_status_flags.sv
module ucb_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic blk_done,
  input  logic clr_avail,
  input  logic clr_unlock,
  output logic avail,
  output logic unlock
);
  // Set has priority over clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail  <= 1'b0;
      unlock <= 1'b0;
    end else begin
      if (blk_done)       avail <= 1'b1;
      else if (clr_avail) avail <= 1'b0;

      if (!lock)           unlock <= 1'b1;
      else if (clr_unlock) unlock <= 1'b0;
    end
  end

  a_r6_avail_on_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> avail);
  a_r8_unlock_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && clr_unlock) |=> unlock);
  a_r7_avail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_avail && !blk_done) |=> !avail);
  a_r7_unlock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !clr_unlock) |=> unlock);
endmodule

// File: rtl/spdif_ucb_capture.sv
module spdif_ucb_capture
  import spdif_ucb_pkg::*;
#(
  parameter int FRAMES = FRAMES_PER_BLOCK,
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              chan_sel,
  input  logic              sf_valid,
  output logic              sf_ready,
  input  logic              sf_chan,
  input  logic              sf_blk_start,
  input  logic              sf_ubit,
  input  logic              sf_cbit,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int IDX_W   = $clog2(FRAMES);
  localparam int NWORDS  = FRAMES / DATA_W;
  localparam int STAT_AD = BANKS * NWORDS;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(STAT_AD);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             commit;
  logic [FRAMES-1:0] vis_bits [BANKS];
  logic             avail;
  logic             unlock;
  logic             stat_wr;
  logic             unused_wdata;

  assign sf_ready     = 1'b1;
  assign stat_wr      = reg_wr && (reg_addr == ADDR_STATUS);
  assign unused_wdata = ^{reg_wdata[DATA_W-1:UNLOCK_BIT+1], reg_wdata[AVAIL_BIT-1:0]};

  ucb_frame_tracker #(.FRAMES(FRAMES)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock         (lock),
    .chan_sel     (chan_sel),
    .sf_valid     (sf_valid),
    .sf_chan      (sf_chan),
    .sf_blk_start (sf_blk_start),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .commit       (commit)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ucb_shadow_bank #(.FRAMES(FRAMES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .bit_in ((bank_e'(b) == BANK_USER) ? sf_ubit : sf_cbit),
      .commit (commit),
      .vis    (vis_bits[b])
    );
  end

  ucb_status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock       (lock),
    .blk_done   (commit),
    .clr_avail  (stat_wr && reg_wdata[AVAIL_BIT]),
    .clr_unlock (stat_wr && reg_wdata[UNLOCK_BIT]),
    .avail      (avail),
    .unlock     (unlock)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int k = 0; k < NWORDS; k++) begin
        if (reg_addr == ADDR_W'(b * NWORDS + k))
          reg_rdata = vis_bits[b][k*DATA_W +: DATA_W];
      end
    end
    if (reg_addr == ADDR_STATUS) begin
      reg_rdata[AVAIL_BIT]  = avail;
      reg_rdata[UNLOCK_BIT] = unlock;
    end
  end

  a_r6_status_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_STATUS) |-> (reg_rdata[DATA_W-1:UNLOCK_BIT+1] == '0
                                   && reg_rdata[AVAIL_BIT-1:0] == '0));
  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sf_ready);
endmodule

// File: tb/spdif_ucb_capture_tb.sv
`timescale 1ns/1ps
module spdif_ucb_capture_tb;
  localparam int NW = 6;
  localparam logic [3:0] ST = 4'd12;

  typedef struct packed {
    logic [31:0] seed;
    logic        sel;
    logic        gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{seed: 32'h0000_1111, sel: 1'b0, gap: 1'b0},
    '{seed: 32'hA5A5_0001, sel: 1'b1, gap: 1'b0},
    '{seed: 32'h1234_5678, sel: 1'b0, gap: 1'b1},
    '{seed: 32'hDEAD_BEEF, sel: 1'b1, gap: 1'b1},
    '{seed: 32'h0F0F_7777, sel: 1'b1, gap: 1'b0},
    '{seed: 32'h5555_AAAA, sel: 1'b0, gap: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, lock, chan_sel, sf_valid, sf_ready, sf_chan, sf_blk_start, sf_ubit, sf_cbit;
  logic reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spdif_ucb_capture u_dut (
    .clk(clk), .rst_n(rst_n), .lock(lock), .chan_sel(chan_sel),
    .sf_valid(sf_valid), .sf_ready(sf_ready), .sf_chan(sf_chan),
    .sf_blk_start(sf_blk_start), .sf_ubit(sf_ubit), .sf_cbit(sf_cbit),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic gen_bit(int unsigned seed, int n, int c, int t);
    int unsigned h;
    h = seed ^ (32'(n) * 32'h9E3779B1) ^ (32'(c) * 32'h85EBCA6B) ^ (32'(t) * 32'hC2B2AE35);
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return h[7];
  endfunction

  function automatic logic [31:0] exp_word(int unsigned seed, int sel, int t, int k);
    logic [31:0] w;
    for (int j = 0; j < 32; j++) w[j] = gen_bit(seed, 32 * k + j, sel, t);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic check_block(string req, int unsigned seed, int sel);
    for (int k = 0; k < NW; k++) begin
      chk_reg(req, 4'(k), exp_word(seed, sel, 0, k));
      chk_reg(req, 4'(NW + k), exp_word(seed, sel, 1, k));
    end
  endtask

  task automatic wr_status(logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ST; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic send_frames(int unsigned seed, int first, int last, bit with_start,
                             bit gap, bit clr_commit);
    for (int n = first; n <= last; n++) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        sf_valid     = 1'b1;
        sf_chan      = 1'(c);
        sf_blk_start = with_start && (n == 0) && (c == 0);
        sf_ubit      = gen_bit(seed, n, c, 0);
        sf_cbit      = gen_bit(seed, n, c, 1);
        if (clr_commit && n == 191 && c == int'(chan_sel)) begin
          reg_wr = 1'b1; reg_addr = ST; reg_wdata = 32'h100;
        end else begin
          reg_wr = 1'b0;
        end
        if (gap) begin
          @(negedge clk);
          reg_wr = 1'b0;
          sf_valid = 1'b0; sf_blk_start = 1'b1; sf_chan = chan_sel;
          sf_ubit = 1'b1; sf_cbit = 1'b1;
        end
      end
    end
    @(negedge clk);
    sf_valid = 1'b0; sf_blk_start = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lock = 1'b1; chan_sel = 1'b0;
    sf_valid = 1'b0; sf_chan = 1'b0; sf_blk_start = 1'b0; sf_ubit = 1'b0; sf_cbit = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents; R9: ready
    for (int a = 0; a <= 12; a++) chk_reg("R1", 4'(a), 32'h0);
    chk("R9", {31'h0, sf_ready}, 32'h1);

    // R2, R4, R9 (gaps), R6, R7 from the vector table
    for (int i = 0; i < 6; i++) begin
      chan_sel = VECS[i].sel;
      send_frames(VECS[i].seed, 0, 191, 1'b1, VECS[i].gap, 1'b0);
      check_block(VECS[i].gap ? "R2 R4 R9" : "R2 R4", VECS[i].seed, int'(VECS[i].sel));
      chk_reg("R6", ST, 32'h100);
      wr_status(32'h100);
      chk_reg("R7", ST, 32'h0);
    end

    // R3: partial block leaves previous contents; R10: restart mid-block
    chan_sel = 1'b0;
    send_frames(32'h7000_0001, 0, 99, 1'b1, 1'b0, 1'b0);
    check_block("R3", VECS[5].seed, 0);
    chk_reg("R3", ST, 32'h0);
    send_frames(32'h7000_0002, 0, 191, 1'b1, 1'b0, 1'b0);
    check_block("R10", 32'h7000_0002, 0);
    chk_reg("R10", ST, 32'h100);
    wr_status(32'h100);

    // R5: lock loss mid-block discards it and waits for a block start
    send_frames(32'h7000_0003, 0, 99, 1'b1, 1'b0, 1'b0);
    @(negedge clk); lock = 1'b0;
    @(negedge clk); lock = 1'b1;
    send_frames(32'h7000_0003, 100, 191, 1'b0, 1'b0, 1'b0);
    check_block("R5", 32'h7000_0002, 0);
    chk_reg("R5 R6", ST, 32'h200);
    wr_status(32'h0);
    chk_reg("R7", ST, 32'h200);
    wr_status(32'h200);
    chk_reg("R7", ST, 32'h0);
    chan_sel = 1'b1;
    send_frames(32'h7000_0004, 0, 191, 1'b1, 1'b0, 1'b0);
    check_block("R5", 32'h7000_0004, 1);
    wr_status(32'h100);
    chk_reg("R7", ST, 32'h0);

    // R8: unlock set and cleared in the same cycle
    @(negedge clk);
    lock = 1'b0; reg_wr = 1'b1; reg_addr = ST; reg_wdata = 32'h200;
    @(negedge clk);
    lock = 1'b1; reg_wr = 1'b0; reg_wdata = '0;
    chk_reg("R8", ST, 32'h200);
    wr_status(32'h200);

    // R8: block completion coinciding with an avail clear
    send_frames(32'h7000_0005, 0, 191, 1'b1, 1'b0, 1'b1);
    chk_reg("R8", ST, 32'h100);
    check_block("R2", 32'h7000_0005, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule